// File: doc/BRIEF.md
# System Control Register Bank

This block is a small bank of eight 32-bit control registers that sits beside a processor core. The core moves data in and out through single-cycle register-transfer commands: each command carries the full 32-bit instruction word, and the bank takes the register number from that word. A separate debug port gives direct indexed access to the same registers, so that a debugger can inspect and patch them without issuing instructions.

Two registers have a fixed role. Register 0 always reads as the identification constant 0x41440110. Register 1 holds four live configuration bits that leave the block as plain output pins: program address width, data address width, late-abort timing and byte order. Whenever a write changes any of those four pins, the block raises a one-cycle mode-change pulse so that the core can re-evaluate its operating mode. Registers 2 to 7 are general storage.

The command side has no back-pressure: the bank accepts every command in the cycle in which `cmd_valid` is high, so a caller never has to wait. A write takes effect at that clock edge, and a read returns its data in the same cycle. The debug port is a plain strobe interface with no handshake.

Top module: `cpr_sysctl`

## Requirements
- R1: The register number is instruction bits 18:16; bit 19 of the instruction is ignored, so field values 8 to 15 select registers 0 to 7.
- R2: A read of register 0, from either port, returns 0x41440110 whatever was last written to it.
- R3: During and after reset, register 1 holds strap input bit n at bit 4+n (n = 0..3) with all other bits zero, the four configuration outputs equal the straps, registers 2 to 7 read zero and the mode-change pulse is low.
- R4: After a write to register 1, the outputs follow the written bits from the next cycle: bit 4 drives `cfg_prog_wide`, bit 5 `cfg_data_wide`, bit 6 `cfg_late_abort`, bit 7 `cfg_big_endian`. The outputs change on no other event.
- R5: `mode_chg` is high for exactly the one cycle after a write to register 1 that changed at least one configuration output, and stays low after a write that changed none.
- R6: Registers 1 to 7 read back the full 32-bit value last written to them.
- R7: `rsp_done` is high in every cycle in which `cmd_valid` is high; for a read, `rsp_rdata` carries the selected register in the same cycle, and it is zero when no read is issued.
- R8: The debug port reads and writes registers 0 to 7 by `dbg_idx`, with the same effects as commands, including the register 1 outputs and pulse.
- R9: A debug write with `dbg_idx` of 8 or more changes nothing, and a debug read with such an index returns zero.
- R10: When a command write and a debug write fall in the same cycle, the command write is performed and the debug write is dropped.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| strap_cfg | input | 4 | Reset value of the four configuration bits (bit 0 program width .. bit 3 byte order) |
| cmd_valid | input | 1 | Command present this cycle, always accepted |
| cmd_write | input | 1 | 1 = write, 0 = read |
| cmd_instr | input | 32 | Instruction word; bits 18:16 select the register |
| cmd_wdata | input | 32 | Write data |
| rsp_done | output | 1 | Command completed this cycle |
| rsp_rdata | output | 32 | Read data for a command read |
| dbg_wr | input | 1 | Debug write strobe |
| dbg_rd | input | 1 | Debug read strobe |
| dbg_idx | input | 4 | Debug register index |
| dbg_wdata | input | 32 | Debug write data |
| dbg_rdata | output | 32 | Debug read data |
| cfg_prog_wide | output | 1 | Program address width select |
| cfg_data_wide | output | 1 | Data address width select |
| cfg_late_abort | output | 1 | Late-abort timing select |
| cfg_big_endian | output | 1 | Big-endian byte order |
| mode_chg | output | 1 | One-cycle pulse after a configuration change |

## Verification
A corrupted storage register shows up on the very next read of it from either port, so every write in the bench is followed at once by a read-back. A wrong copy of register 1 appears on the configuration pins one cycle after the write and, if the stored bits disagree with the pins, a later read exposes it as well. A pulse generator that tracks the wrong previous value shows either a missing pulse in the cycle after a changing write or a spurious one after a write that kept the bits, and both cases are checked in that exact cycle.

// File: rtl/cpr_pkg.sv
package cpr_pkg;
  localparam int DW        = 32;
  localparam int NREG      = 8;
  localparam int IDXW      = $clog2(NREG);
  localparam int DBG_IW    = IDXW + 1;
  localparam int CFG_W     = 4;
  localparam int CFG_LSB   = 4;
  localparam int SEL_LSB   = 16;
  localparam logic [DW-1:0] ID_VALUE = 32'h4144_0110;
  localparam int CFG_REG   = 1;

  typedef struct packed {
    logic            en;
    logic [IDXW-1:0] idx;
    logic [DW-1:0]   data;
  } wr_req_t;
endpackage

// File: rtl/cpr_bank.sv
module cpr_bank
  import cpr_pkg::*;
(
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic [CFG_W-1:0]     strap_cfg,
  input  wr_req_t              wr,
  input  logic [IDXW-1:0]      ra_idx,
  output logic [DW-1:0]        ra_data,
  input  logic [IDXW-1:0]      rb_idx,
  output logic [DW-1:0]        rb_data,
  output logic [CFG_W-1:0]     cfg_bits
);
  logic [DW-1:0] regs [NREG];

  assign regs[0] = '0;

  for (genvar k = 1; k < NREG; k++) begin : g_reg
    logic [DW-1:0] rst_val;
    if (k == CFG_REG) begin : g_cfg
      assign rst_val = DW'(strap_cfg) << CFG_LSB;
    end else begin : g_plain
      assign rst_val = '0;
    end
    always_ff @(posedge clk) begin
      if (!rst_n)
        regs[k] <= rst_val;
      else if (wr.en && wr.idx == IDXW'(k))
        regs[k] <= wr.data;
    end
  end

  assign ra_data  = (ra_idx == '0) ? ID_VALUE : regs[ra_idx];
  assign rb_data  = (rb_idx == '0) ? ID_VALUE : regs[rb_idx];
  assign cfg_bits = regs[CFG_REG][CFG_LSB +: CFG_W];

  // R6
  stored_value_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr.en && wr.idx != '0) |=> regs[$past(wr.idx)] == $past(wr.data));

  // R4
  cfg_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(wr.en && wr.idx == IDXW'(CFG_REG)) |=> $stable(cfg_bits));
endmodule

// File: rtl/cpr_mode_watch.sv
module cpr_mode_watch
  import cpr_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  wr_req_t          wr,
  input  logic [CFG_W-1:0] cfg_now,
  output logic             mode_chg
);
  logic hits_cfg;
  logic differs;

  assign hits_cfg = wr.en && wr.idx == IDXW'(CFG_REG);
  assign differs  = wr.data[CFG_LSB +: CFG_W] != cfg_now;

  always_ff @(posedge clk) begin
    if (!rst_n) mode_chg <= 1'b0;
    else        mode_chg <= hits_cfg && differs;
  end

  // R5
  pulse_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mode_chg |-> cfg_now != $past(cfg_now));

  // R5
  pulse_needed_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(rst_n) && cfg_now != $past(cfg_now)) |-> mode_chg);
endmodule

// File: rtl/cpr_sysctl.sv
module cpr_sysctl
  import cpr_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic [3:0]  strap_cfg,
  input  logic        cmd_valid,
  input  logic        cmd_write,
  input  logic [31:0] cmd_instr,
  input  logic [31:0] cmd_wdata,
  output logic        rsp_done,
  output logic [31:0] rsp_rdata,
  input  logic        dbg_wr,
  input  logic        dbg_rd,
  input  logic [3:0]  dbg_idx,
  input  logic [31:0] dbg_wdata,
  output logic [31:0] dbg_rdata,
  output logic        cfg_prog_wide,
  output logic        cfg_data_wide,
  output logic        cfg_late_abort,
  output logic        cfg_big_endian,
  output logic        mode_chg
);
  logic [IDXW-1:0]  cmd_idx;
  logic             cmd_wr;
  logic             dbg_in_range;
  logic             dbg_wr_ok;
  wr_req_t          wr;
  logic [DW-1:0]    ra_data;
  logic [DW-1:0]    rb_data;
  logic [CFG_W-1:0] cfg_bits;
  logic             unused_instr;

  assign cmd_idx      = cmd_instr[SEL_LSB +: IDXW];
  assign unused_instr = ^{cmd_instr[DW-1:SEL_LSB+IDXW], cmd_instr[SEL_LSB-1:0]};
  assign cmd_wr       = cmd_valid && cmd_write;
  assign dbg_in_range = !dbg_idx[DBG_IW-1];
  assign dbg_wr_ok    = dbg_wr && dbg_in_range;

  always_comb begin
    wr.en   = cmd_wr || dbg_wr_ok;
    wr.idx  = cmd_wr ? cmd_idx   : dbg_idx[IDXW-1:0];
    wr.data = cmd_wr ? cmd_wdata : dbg_wdata;
  end

  cpr_bank u_bank (
    .clk       (clk),
    .rst_n     (rst_n),
    .strap_cfg (strap_cfg),
    .wr        (wr),
    .ra_idx    (cmd_idx),
    .ra_data   (ra_data),
    .rb_idx    (dbg_idx[IDXW-1:0]),
    .rb_data   (rb_data),
    .cfg_bits  (cfg_bits)
  );

  cpr_mode_watch u_watch (
    .clk      (clk),
    .rst_n    (rst_n),
    .wr       (wr),
    .cfg_now  (cfg_bits),
    .mode_chg (mode_chg)
  );

  assign rsp_done  = cmd_valid;
  assign rsp_rdata = (cmd_valid && !cmd_write) ? ra_data : '0;
  assign dbg_rdata = (dbg_rd && dbg_in_range) ? rb_data : '0;

  assign cfg_prog_wide  = cfg_bits[0];
  assign cfg_data_wide  = cfg_bits[1];
  assign cfg_late_abort = cfg_bits[2];
  assign cfg_big_endian = cfg_bits[3];

  // R2
  id_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_valid && !cmd_write && cmd_instr[18:16] == 3'd0) |-> rsp_rdata == ID_VALUE);

  // R9
  dbg_oob_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (dbg_rd && dbg_idx >= 4'd8) |-> dbg_rdata == '0);

  // R7
  done_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_valid |-> rsp_done);
endmodule

// File: tb/cpr_sysctl_bench.sv
module cpr_sysctl_bench;
  localparam int CLK_PERIOD = 10;
  localparam logic [31:0] ID = 32'h4144_0110;

  typedef struct packed {
    logic [3:0]  fld;
    logic [31:0] wd;
    logic [31:0] exp_rd;
  } vec_t;

  localparam int NV = 7;
  localparam vec_t VECS [NV] = '{
    '{4'h2, 32'hDEAD_BEEF, 32'hDEAD_BEEF},
    '{4'hA, 32'h1234_5678, 32'h1234_5678},
    '{4'h0, 32'hFFFF_FFFF, ID},
    '{4'h7, 32'hA5A5_A5A5, 32'hA5A5_A5A5},
    '{4'hF, 32'h0F0F_0F0F, 32'h0F0F_0F0F},
    '{4'h3, 32'h0000_0000, 32'h0000_0000},
    '{4'h1, 32'h0000_00F3, 32'h0000_00F3}
  };

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [3:0]  strap_cfg = 4'b1010;
  logic        cmd_valid = 1'b0, cmd_write = 1'b0;
  logic [31:0] cmd_instr = '0, cmd_wdata = '0;
  logic        rsp_done;
  logic [31:0] rsp_rdata;
  logic        dbg_wr = 1'b0, dbg_rd = 1'b0;
  logic [3:0]  dbg_idx = '0;
  logic [31:0] dbg_wdata = '0;
  logic [31:0] dbg_rdata;
  logic        cfg_prog_wide, cfg_data_wide, cfg_late_abort, cfg_big_endian;
  logic        mode_chg;

  int checks = 0;
  int fails  = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  cpr_sysctl u_cpr_sysctl (.*);

  function automatic logic [31:0] instr_for(input logic [3:0] fld);
    return {12'hEE1, fld, 16'h0F10};
  endfunction

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  function automatic logic [3:0] cfg_pins();
    return {cfg_big_endian, cfg_late_abort, cfg_data_wide, cfg_prog_wide};
  endfunction

  task automatic cmd_wr_t(input logic [3:0] fld, input logic [31:0] d);
    @(negedge clk);
    cmd_valid = 1; cmd_write = 1; cmd_instr = instr_for(fld); cmd_wdata = d;
    @(negedge clk);
    cmd_valid = 0; cmd_write = 0;
    #1;
  endtask

  task automatic cmd_rd_t(input logic [3:0] fld, output logic [31:0] d, output logic done);
    @(negedge clk);
    cmd_valid = 1; cmd_write = 0; cmd_instr = instr_for(fld);
    #1;
    d = rsp_rdata; done = rsp_done;
    @(negedge clk);
    cmd_valid = 0;
  endtask

  task automatic dbg_wr_t(input logic [3:0] i, input logic [31:0] d);
    @(negedge clk);
    dbg_wr = 1; dbg_idx = i; dbg_wdata = d;
    @(negedge clk);
    dbg_wr = 0;
    #1;
  endtask

  task automatic dbg_rd_t(input logic [3:0] i, output logic [31:0] d);
    @(negedge clk);
    dbg_rd = 1; dbg_idx = i;
    #1;
    d = dbg_rdata;
    @(negedge clk);
    dbg_rd = 0;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end

  initial begin
    logic [31:0] rd;
    logic done;
    repeat (3) @(negedge clk);
    // R3 state while still in reset
    check("R3 cfg in reset", {28'd0, cfg_pins()}, 32'h0000_000A);
    rst_n = 1;
    // R3 reset state
    cmd_rd_t(4'h1, rd, done);
    check("R3 reg1 reset", rd, 32'h0000_00A0);
    cmd_rd_t(4'h2, rd, done);
    check("R3 reg2 reset", rd, 32'h0);
    check("R3 cfg pins", {28'd0, cfg_pins()}, 32'h0000_000A);
    check("R3 pulse low", {31'd0, mode_chg}, 32'h0);
    // R7 done and idle data
    check("R7 read done", {31'd0, done}, 32'h1);
    #1;
    check("R7 idle done", {31'd0, rsp_done}, 32'h0);
    check("R7 idle rdata", rsp_rdata, 32'h0);

    // Table: write then read back (R1, R2, R6)
    for (int v = 0; v < NV; v++) begin
      cmd_wr_t(VECS[v].fld, VECS[v].wd);
      cmd_rd_t(VECS[v].fld, rd, done);
      check("R1/R2/R6 table readback", rd, VECS[v].exp_rd);
    end
    // R1: field 9 aliases register 1
    cmd_rd_t(4'h9, rd, done);
    check("R1 alias of reg1", rd, 32'h0000_00F3);

    // R4/R5: changing write
    cmd_wr_t(4'h1, 32'h0000_0050);
    check("R5 pulse after change", {31'd0, mode_chg}, 32'h1);
    check("R4 cfg after write", {28'd0, cfg_pins()}, 32'h0000_0005);
    @(negedge clk); #1;
    check("R5 pulse one cycle", {31'd0, mode_chg}, 32'h0);
    // R5: same bits 7:4, only low bits differ
    cmd_wr_t(4'h1, 32'h0000_005C);
    check("R5 no pulse unchanged", {31'd0, mode_chg}, 32'h0);
    check("R4 cfg unchanged", {28'd0, cfg_pins()}, 32'h0000_0005);

    // R8 debug port
    dbg_rd_t(4'h0, rd);
    check("R8 dbg id read", rd, ID);
    dbg_wr_t(4'h4, 32'hCAFE_0004);
    cmd_rd_t(4'h4, rd, done);
    check("R8 dbg write seen by cmd", rd, 32'hCAFE_0004);
    dbg_wr_t(4'h1, 32'h0000_0080);
    check("R8 dbg pulse", {31'd0, mode_chg}, 32'h1);
    check("R8 dbg cfg", {28'd0, cfg_pins()}, 32'h0000_0008);
    dbg_rd_t(4'h4, rd);
    check("R8 dbg read reg4", rd, 32'hCAFE_0004);

    // R9 out of range
    dbg_wr_t(4'h9, 32'h0000_0070);
    check("R9 no pulse", {31'd0, mode_chg}, 32'h0);
    check("R9 cfg kept", {28'd0, cfg_pins()}, 32'h0000_0008);
    cmd_rd_t(4'h1, rd, done);
    check("R9 reg1 kept", rd, 32'h0000_0080);
    dbg_wr_t(4'hC, 32'h1111_1111);
    cmd_rd_t(4'h4, rd, done);
    check("R9 reg4 kept", rd, 32'hCAFE_0004);
    dbg_rd_t(4'hC, rd);
    check("R9 oob read zero", rd, 32'h0);

    // R10 simultaneous writes
    @(negedge clk);
    cmd_valid = 1; cmd_write = 1; cmd_instr = instr_for(4'h5); cmd_wdata = 32'h0000_0011;
    dbg_wr = 1; dbg_idx = 4'h5; dbg_wdata = 32'h0000_0022;
    @(negedge clk);
    cmd_valid = 0; cmd_write = 0; dbg_wr = 0;
    cmd_rd_t(4'h5, rd, done);
    check("R10 command wins", rd, 32'h0000_0011);

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end
endmodule